// File: doc/BRIEF.md
# Integer Execution Unit (ALU, Shifter and Branch Compare)

This block is the combinational execute stage for the base 32-bit integer instruction set. It takes two operands chosen upstream (register/register or register/immediate), the 3-bit operation field of the instruction, one bit carrying instruction bit 30 (the "alternate" bit) and a flag that marks an immediate-form instruction. It returns a 32-bit result for the writeback path.

The operation field also drives a separate branch-condition output. That output compares the same two operands as a conditional branch would, so the fetch logic can decide whether to redirect without running a second pass. Operand selection, immediate extraction, register access and program-counter update are all done outside the block.

Top module: `rv32i_exec_unit`

## Requirements
- R1: Operation field 000 gives the sum, 100 gives XOR, 110 gives OR and 111 gives AND of the two operands.
- R2: In register mode (imm_sel_i=0) with field 000, alt_i=1 gives opa_i minus opb_i and alt_i=0 gives the sum.
- R3: In immediate mode (imm_sel_i=1) with field 000, the result is always the sum, whatever the value of alt_i.
- R4: With field 101, alt_i=1 gives an arithmetic right shift that copies bit 31 into the vacated positions, and alt_i=0 gives a logical right shift that fills with zeros.
- R5: Every shift takes its amount from opb_i[4:0] alone. Bits 31:5 of opb_i have no effect on a shift result.
- R6: A shift amount of 0 returns opa_i unchanged. An arithmetic right shift of a negative value by 31 returns 32'hFFFFFFFF.
- R7: Field 010 returns 1 when opa_i is less than opb_i as signed numbers and 0 otherwise. Field 011 does the same comparison as unsigned numbers (so opa_i=1 against opb_i=32'hFFFFFFFF gives 1 for 011 and 0 for 010).
- R8: branch_o follows the field: 000 equal, 001 not equal, 100 signed less than, 101 signed greater or equal, 110 unsigned less than, 111 unsigned greater or equal.
- R9: With field 010 or 011, branch_o is 0.
- R10: Field 001 shifts opa_i left and fills the vacated low bits with zeros.
- R11: alt_i has no effect on the result when the field is 001, 010, 011, 100, 110 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | First operand (rs1 value) |
| opb_i | input | 32 | Second operand (rs2 value or sign-extended immediate) |
| funct3_i | input | 3 | Operation field of the instruction |
| alt_i | input | 1 | Instruction bit 30: selects subtract or arithmetic shift |
| imm_sel_i | input | 1 | 1 for immediate-form instructions |
| result_o | output | 32 | Arithmetic, logic or shift result |
| branch_o | output | 1 | Branch condition selected by funct3_i |

## Verification
The result path and the branch comparator work on the same operands in the same cycle. A single input pattern therefore produces both a subtract or shift result and an equality or ordering decision. The bench drives patterns in which the two paths must agree, such as a subtraction that returns zero while the field-000 branch reports equal, or a set-less-than together with field-100 ordering on the same signed pair. Every clock, it compares both outputs against one behavioural model. A mismatch on either output, including a branch that stays high under field 010 or 011, is counted against the requirement that pattern targets.

// File: rtl/rv32i_exec_pkg.sv
package rv32i_exec_pkg;
  localparam int XLEN = 32;
  localparam int SHW  = $clog2(XLEN);

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SLL  = 3'b001,
    OP_SLT  = 3'b010,
    OP_SLTU = 3'b011,
    OP_XOR  = 3'b100,
    OP_SHR  = 3'b101,
    OP_OR   = 3'b110,
    OP_AND  = 3'b111
  } alu_op_e;

  typedef enum logic [2:0] {
    BR_EQ  = 3'b000,
    BR_NE  = 3'b001,
    BR_LT  = 3'b100,
    BR_GE  = 3'b101,
    BR_LTU = 3'b110,
    BR_GEU = 3'b111
  } br_op_e;

  typedef struct packed {
    logic eq;
    logic lt_s;
    logic lt_u;
  } cmp_flags_t;
endpackage

// File: rtl/rv32i_exec_addsub.sv
module rv32i_exec_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] b_eff;
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
endmodule

// File: rtl/rv32i_exec_cmp.sv
module rv32i_exec_cmp
  import rv32i_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output cmp_flags_t   flags_o
);
  logic sign_diff;
  assign sign_diff     = a_i[W-1] ^ b_i[W-1];
  assign flags_o.eq    = (a_i == b_i);
  assign flags_o.lt_u  = (a_i < b_i);
  // signed order: differing signs decide directly, else magnitude order
  assign flags_o.lt_s  = sign_diff ? a_i[W-1] : flags_o.lt_u;
endmodule

// File: rtl/rv32i_exec_shift.sv
module rv32i_exec_shift #(
  parameter int W   = 32,
  parameter int AMT = $clog2(W)
) (
  input  logic [W-1:0]   data_i,
  input  logic [AMT-1:0] amt_i,
  input  logic           left_i,
  input  logic           arith_i,
  output logic [W-1:0]   data_o
);
  logic [W-1:0] rev_in, rev_out;
  logic [W-1:0] stage [AMT+1];
  logic         fill;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = data_i[W-1-i];
    assign rev_out[i] = stage[AMT][W-1-i];
  end

  // left shift reuses the right shifter on bit-reversed data
  assign stage[0] = left_i ? rev_in : data_i;
  assign fill     = arith_i & ~left_i & data_i[W-1];

  for (genvar k = 0; k < AMT; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
  end

  assign data_o = left_i ? rev_out : stage[AMT];
endmodule

// File: rtl/rv32i_exec_unit.sv
module rv32i_exec_unit
  import rv32i_exec_pkg::*;
(
  input  logic [31:0] opa_i,
  input  logic [31:0] opb_i,
  input  logic [2:0]  funct3_i,
  input  logic        alt_i,
  input  logic        imm_sel_i,
  output logic [31:0] result_o,
  output logic        branch_o
);
  logic [XLEN-1:0] sum, shifted;
  cmp_flags_t      flags;
  logic            do_sub;
  alu_op_e         op;

  assign op     = alu_op_e'(funct3_i);
  assign do_sub = alt_i & ~imm_sel_i & (op == OP_ADD);

  rv32i_exec_addsub #(.W(XLEN)) u_addsub (
    .a_i(opa_i), .b_i(opb_i), .sub_i(do_sub), .sum_o(sum)
  );

  rv32i_exec_cmp #(.W(XLEN)) u_cmp (
    .a_i(opa_i), .b_i(opb_i), .flags_o(flags)
  );

  rv32i_exec_shift #(.W(XLEN), .AMT(SHW)) u_shift (
    .data_i (opa_i),
    .amt_i  (opb_i[SHW-1:0]),
    .left_i (op == OP_SLL),
    .arith_i(alt_i),
    .data_o (shifted)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  result_o = sum;
      OP_SLL,
      OP_SHR:  result_o = shifted;
      OP_SLT:  result_o = {{(XLEN-1){1'b0}}, flags.lt_s};
      OP_SLTU: result_o = {{(XLEN-1){1'b0}}, flags.lt_u};
      OP_XOR:  result_o = opa_i ^ opb_i;
      OP_OR:   result_o = opa_i | opb_i;
      OP_AND:  result_o = opa_i & opb_i;
      default: result_o = '0;
    endcase
  end

  always_comb begin
    case (br_op_e'(funct3_i))
      BR_EQ:   branch_o = flags.eq;
      BR_NE:   branch_o = ~flags.eq;
      BR_LT:   branch_o = flags.lt_s;
      BR_GE:   branch_o = ~flags.lt_s;
      BR_LTU:  branch_o = flags.lt_u;
      BR_GEU:  branch_o = ~flags.lt_u;
      default: branch_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rv32i_exec_unit_chk.sv
module rv32i_exec_unit_chk (
  input logic [31:0] opa_i,
  input logic [31:0] opb_i,
  input logic [2:0]  funct3_i,
  input logic        alt_i,
  input logic        imm_sel_i,
  input logic [31:0] result_o,
  input logic        branch_o
);
  always_comb begin
    if (funct3_i[2:1] == 2'b01)
      assert_no_branch_R9: assert (!branch_o);
    if (funct3_i[2:1] == 2'b01)
      assert_slt_bit_R7: assert (result_o[31:1] == 31'd0);
    if (imm_sel_i && funct3_i == 3'b000)
      assert_imm_add_R3: assert (result_o - opb_i == opa_i);
    if (!imm_sel_i && alt_i && funct3_i == 3'b000)
      assert_sub_inverse_R2: assert (result_o + opb_i == opa_i);
    if (funct3_i[1:0] == 2'b01 && opb_i[4:0] == 5'd0)
      assert_zero_shift_R6: assert (result_o == opa_i);
    if (funct3_i[2:1] == 2'b11 && opa_i == opb_i)
      assert_unsigned_equal_R8: assert (branch_o == funct3_i[0]);
  end
endmodule

bind rv32i_exec_unit rv32i_exec_unit_chk u_chk (
  .opa_i(opa_i), .opb_i(opb_i), .funct3_i(funct3_i), .alt_i(alt_i),
  .imm_sel_i(imm_sel_i), .result_o(result_o), .branch_o(branch_o)
);

// File: tb/rv32i_exec_unit_test.sv
module rv32i_exec_unit_test;
  logic        clk = 1'b0;
  logic [31:0] opa, opb, res;
  logic [2:0]  f3;
  logic        alt, imm, br;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  rv32i_exec_unit uut (
    .opa_i(opa), .opb_i(opb), .funct3_i(f3), .alt_i(alt),
    .imm_sel_i(imm), .result_o(res), .branch_o(br)
  );

  function automatic logic [31:0] model_res(logic [31:0] a, logic [31:0] b,
                                            logic [2:0] f, logic s, logic i);
    int sh = int'(b[4:0]);
    case (f)
      3'd0: return (s && !i) ? a - b : a + b;
      3'd1: return a << sh;
      3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'd3: return (a < b) ? 32'd1 : 32'd0;
      3'd4: return a ^ b;
      3'd5: begin
        logic [31:0] v = a;
        for (int k = 0; k < sh; k++) v = {s ? v[31] : 1'b0, v[31:1]};
        return v;
      end
      3'd6: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic logic model_br(logic [31:0] a, logic [31:0] b, logic [2:0] f);
    case (f)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      3'd6: return a < b;
      3'd7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [2:0] f,
                     input logic s, input logic i, input string tag);
    logic [31:0] er;
    logic        eb;
    @(negedge clk);
    opa = a; opb = b; f3 = f; alt = s; imm = i;
    er = model_res(a, b, f, s, i);
    eb = model_br(a, b, f);
    @(posedge clk);
    #2;
    n_cmp++;
    if (res !== er) begin
      n_bad++;
      $display("FAIL %s result f3=%b alt=%b imm=%b actual=%h expected=%h", tag, f, s, i, res, er);
    end
    n_cmp++;
    if (br !== eb) begin
      n_bad++;
      $display("FAIL %s branch f3=%b actual=%b expected=%b", tag, f, br, eb);
    end
  endtask

  function automatic logic [31:0] next_rand(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    opa = '0; opb = '0; f3 = '0; alt = 0; imm = 0;
    @(posedge clk); #2;
    n_cmp++; // reset/idle state: zero operands add to zero, equal branch
    if (res !== 32'd0 || br !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 idle actual=%h/%b expected=00000000/1", res, br);
    end
    run(32'd7, 32'd5, 3'b000, 0, 0, "R1");
    run(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b100, 0, 0, "R1");
    run(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b110, 0, 0, "R1");
    run(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b111, 0, 0, "R1");
    run(32'd7, 32'd7, 3'b000, 1, 0, "R2");            // subtract to zero while branch equal
    run(32'd5, 32'd9, 3'b000, 1, 0, "R2");
    run(32'd5, 32'd9, 3'b000, 1, 1, "R3");
    run(32'h8000_0000, 32'hFFFF_FFFF, 3'b000, 1, 1, "R3");
    run(32'h8000_00F0, 32'd4, 3'b101, 1, 0, "R4");
    run(32'h8000_00F0, 32'd4, 3'b101, 0, 0, "R4");
    run(32'h8000_00F0, 32'd4, 3'b101, 1, 1, "R4");
    run(32'hC000_0001, 32'hFFFF_FFE3, 3'b101, 0, 0, "R5");
    run(32'hC000_0001, 32'h0000_0FE3, 3'b001, 0, 0, "R5");
    run(32'hDEAD_BEEF, 32'h0000_0020, 3'b001, 0, 0, "R6");
    run(32'hDEAD_BEEF, 32'd0, 3'b101, 1, 0, "R6");
    run(32'h8000_0000, 32'd31, 3'b101, 1, 0, "R6");
    run(32'd1, 32'hFFFF_FFFF, 3'b010, 0, 0, "R7");
    run(32'd1, 32'hFFFF_FFFF, 3'b011, 0, 1, "R7");
    run(32'hFFFF_FFFE, 32'd3, 3'b010, 0, 0, "R7");
    for (int f = 0; f < 8; f++) begin
      run(32'hFFFF_FFFE, 32'd3, 3'(f), 0, 0, "R8");
      run(32'd3, 32'd3, 3'(f), 0, 0, "R8");
      run(32'd3, 32'hFFFF_FFFE, 3'(f), 0, 0, "R8");
    end
    run(32'd2, 32'd2, 3'b010, 0, 0, "R9");
    run(32'd1, 32'd2, 3'b011, 0, 0, "R9");
    run(32'h0000_0003, 32'd30, 3'b001, 0, 0, "R10");
    foreach (f3_list[j]) run(32'h8765_4321, 32'h0000_0107, f3_list[j], 1, 0, "R11");
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      seed = next_rand(seed); a = seed;
      seed = next_rand(seed); b = seed;
      run(a, b, seed[2:0], seed[9], seed[17], "R1");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [2:0] f3_list [6] = '{3'b001, 3'b010, 3'b011, 3'b100, 3'b110, 3'b111};

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule